// File: doc/BRIEF.md
# Byte-wide flash command interpreter

This block is the synthesizable command front end of a byte-wide parallel flash model. It watches write strobes on an 18-bit address bus and an 8-bit data bus. Write cycles at two fixed unlock addresses are assembled into commands. A command can program one byte, erase the whole array, erase a 64 KB sector, erase a 4 KB page, or switch an identification read mode on and off.

While an embedded operation runs, the block reports busy and replaces read data with status. Bit 7 works as a data-polling flag and bit 6 toggles on every read. Operation lengths are set in clock cycles by parameters. The storage is a scaled-down register array. It keeps the sector and page fields of the address and a small number of low offset bits.

Top module: `pflash_cmd_ctrl`

## Requirements
- R1: A byte program is the four writes 0x05555←0xAA, 0x02AAA←0x55, 0x05555←0xA0, then target←value. When the operation completes, the stored byte becomes old AND value. Storage holds one byte per combination of address bits 17:12 and the OFFS_BITS lowest address bits (default 2), so addresses that agree in those bits name the same byte.
- R2: All erases start with the five writes 0x05555←0xAA, 0x02AAA←0x55, 0x05555←0x80, 0x05555←0xAA, 0x02AAA←0x55. A sixth write of 0x10 to 0x05555 then sets every stored byte to 0xFF.
- R3: A sixth erase write of 0x30 to any address sets to 0xFF every byte whose address bits 17:16 match that address, and changes no other byte.
- R4: A sixth erase write of 0x50 to any address sets to 0xFF every byte whose address bits 17:12 match that address, and changes no other byte.
- R5: The writes 0x05555←0xAA, 0x02AAA←0x55, 0x05555←0x90 enter identification mode. In that mode a read with address bits 7:0 equal to 0x00 returns 0xDA, 0x01 returns 0xB5, and any other value returns 0x00.
- R6: The writes 0x05555←0xAA, 0x02AAA←0x55, 0x05555←0xF0 leave identification mode, and reads then return stored bytes.
- R7: While busy, read bit 7 is the complement of bit 7 of the value being programmed during a program, and 0 during any erase. After completion, reads return the stored data.
- R8: While busy, bit 6 of read data is 0 on the first read after the operation starts and inverts on each further read, at any address. Bits 5:0 read 0.
- R9: `busy` rises in the cycle after the final command write. It stays high for PROG_CYCLES (default 8) cycles for a program, PAGE_CYCLES and SECT_CYCLES (default 24) for page and sector erase, and CHIP_CYCLES (default 48) for chip erase.
- R10: A write that does not match the expected unlock address and data returns the decoder to idle with no effect on storage or mode.
- R11: Writes that arrive while busy are ignored and do not advance the command decoder.
- R12: After reset every stored byte is 0xFF, `busy` is 0, read data is 0x00 and identification mode is off.
- R13: Read data is registered. It updates in the cycle after `bus_re` and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_re | input | 1 | Read strobe |
| bus_addr | input | 18 | Byte address for reads and writes |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data or status |
| busy | output | 1 | Embedded operation in progress |

## Verification
Programming is tried with a fresh value over an erased byte and with a second value over the first, which shows that programming can only clear bits. It is also tried through an aliased address, which shows which address bits the storage keeps. Erase is tried with bytes placed in the target page, in a sibling page of the same sector and in another sector, so chip, sector and page scope can each be told apart. Unlock sequences broken at the second cycle, and a full command issued during a long erase, show that stray writes leave the decoder with no pending state. Consecutive status reads during program and erase separate the polling bit from the toggle bit.

// File: rtl/pflash_pkg.sv
package pflash_pkg;

   localparam int PF_AW       = 18;
   localparam int PF_DW       = 8;
   localparam int PF_SEC_W    = 2;
   localparam int PF_PGID_W   = 6;
   localparam int PF_PGID_LSB = 12;

   localparam logic [PF_AW-1:0] PF_UNLOCK_A = 18'h05555;
   localparam logic [PF_AW-1:0] PF_UNLOCK_B = 18'h02AAA;

   localparam logic [PF_DW-1:0] KEY_A      = 8'hAA;
   localparam logic [PF_DW-1:0] KEY_B      = 8'h55;
   localparam logic [PF_DW-1:0] CMD_PROG   = 8'hA0;
   localparam logic [PF_DW-1:0] CMD_ERASE  = 8'h80;
   localparam logic [PF_DW-1:0] CMD_ID_ON  = 8'h90;
   localparam logic [PF_DW-1:0] CMD_ID_OFF = 8'hF0;
   localparam logic [PF_DW-1:0] SEL_CHIP   = 8'h10;
   localparam logic [PF_DW-1:0] SEL_SECT   = 8'h30;
   localparam logic [PF_DW-1:0] SEL_PAGE   = 8'h50;
   localparam logic [PF_DW-1:0] ID_MAKER   = 8'hDA;
   localparam logic [PF_DW-1:0] ID_PART    = 8'hB5;

   typedef enum logic [2:0] {
      OP_NONE, OP_PROG, OP_CHIP, OP_SECT, OP_PAGE
   } op_kind_e;

   typedef enum logic [2:0] {
      DS_IDLE, DS_UNL1, DS_UNL2, DS_ERS3, DS_ERS4, DS_ERS5, DS_PGM
   } dec_state_e;

endpackage

// File: rtl/pflash_seq_decoder.sv
module pflash_seq_decoder
   import pflash_pkg::*;
#(
   parameter int OFFS_BITS = 2,
   localparam int IDX_W = PF_PGID_W + OFFS_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [PF_AW-1:0]  addr,
   input  logic [PF_DW-1:0]  data,
   output logic              start,
   output op_kind_e          kind,
   output logic [IDX_W-1:0]  idx,
   output logic [PF_DW-1:0]  wdata,
   output logic              id_enter,
   output logic              id_exit,
   output dec_state_e        state_o
);

   dec_state_e state_q, state_d;
   logic       at_a, at_b;

   assign at_a    = (addr == PF_UNLOCK_A);
   assign at_b    = (addr == PF_UNLOCK_B);
   assign idx     = {addr[PF_AW-1 -: PF_PGID_W], addr[OFFS_BITS-1:0]};
   assign wdata   = data;
   assign state_o = state_q;

   always_comb begin
      state_d  = state_q;
      start    = 1'b0;
      kind     = OP_NONE;
      id_enter = 1'b0;
      id_exit  = 1'b0;
      if (wr_en) begin
         state_d = DS_IDLE;
         unique case (state_q)
            DS_IDLE: if (at_a && data == KEY_A) state_d = DS_UNL1;
            DS_UNL1: if (at_b && data == KEY_B) state_d = DS_UNL2;
            DS_UNL2: begin
               if (at_a) begin
                  if (data == CMD_PROG)   state_d = DS_PGM;
                  if (data == CMD_ERASE)  state_d = DS_ERS3;
                  if (data == CMD_ID_ON)  id_enter = 1'b1;
                  if (data == CMD_ID_OFF) id_exit  = 1'b1;
               end
            end
            DS_ERS3: if (at_a && data == KEY_A) state_d = DS_ERS4;
            DS_ERS4: if (at_b && data == KEY_B) state_d = DS_ERS5;
            DS_ERS5: begin
               if (at_a && data == SEL_CHIP) begin
                  start = 1'b1;
                  kind  = OP_CHIP;
               end else if (data == SEL_SECT) begin
                  start = 1'b1;
                  kind  = OP_SECT;
               end else if (data == SEL_PAGE) begin
                  start = 1'b1;
                  kind  = OP_PAGE;
               end
            end
            DS_PGM: begin
               start = 1'b1;
               kind  = OP_PROG;
            end
            default: state_d = DS_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= DS_IDLE;
      else        state_q <= state_d;
   end

endmodule

// File: rtl/pflash_op_timer.sv
module pflash_op_timer
   import pflash_pkg::*;
#(
   parameter int IDX_W       = 8,
   parameter int PROG_CYCLES = 8,
   parameter int PAGE_CYCLES = 24,
   parameter int SECT_CYCLES = 24,
   parameter int CHIP_CYCLES = 48,
   localparam int MAX_A = (PROG_CYCLES > PAGE_CYCLES) ? PROG_CYCLES : PAGE_CYCLES,
   localparam int MAX_B = (SECT_CYCLES > CHIP_CYCLES) ? SECT_CYCLES : CHIP_CYCLES,
   localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B,
   localparam int CW    = $clog2(MAX_C) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  op_kind_e          kind_in,
   input  logic [IDX_W-1:0]  idx_in,
   input  logic [PF_DW-1:0]  data_in,
   output logic              busy,
   output logic              done,
   output op_kind_e          kind_q,
   output logic [IDX_W-1:0]  idx_q,
   output logic [PF_DW-1:0]  data_q
);

   logic [CW-1:0] cnt_q;
   logic          busy_q;

   function automatic logic [CW-1:0] span(input op_kind_e k);
      unique case (k)
         OP_PROG: span = CW'(PROG_CYCLES - 1);
         OP_PAGE: span = CW'(PAGE_CYCLES - 1);
         OP_SECT: span = CW'(SECT_CYCLES - 1);
         OP_CHIP: span = CW'(CHIP_CYCLES - 1);
         default: span = '0;
      endcase
   endfunction

   assign busy = busy_q;
   assign done = busy_q && (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
         kind_q <= OP_NONE;
         idx_q  <= '0;
         data_q <= '0;
      end else if (start) begin
         busy_q <= 1'b1;
         cnt_q  <= span(kind_in);
         kind_q <= kind_in;
         idx_q  <= idx_in;
         data_q <= data_in;
      end else if (busy_q) begin
         if (cnt_q == '0) busy_q <= 1'b0;
         else             cnt_q  <= cnt_q - 1'b1;
      end
   end

endmodule

// File: rtl/pflash_store.sv
module pflash_store
   import pflash_pkg::*;
#(
   parameter int OFFS_BITS = 2,
   localparam int IDX_W = PF_PGID_W + OFFS_BITS,
   localparam int DEPTH = 1 << IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              done,
   input  op_kind_e          kind,
   input  logic [IDX_W-1:0]  tgt,
   input  logic [PF_DW-1:0]  data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [PF_DW-1:0]  rd_byte
);

   logic [PF_DW-1:0] mem [DEPTH];

   function automatic logic in_scope(input op_kind_e k,
                                     input logic [IDX_W-1:0] t,
                                     input logic [IDX_W-1:0] ix);
      unique case (k)
         OP_CHIP: in_scope = 1'b1;
         OP_SECT: in_scope = (ix[IDX_W-1 -: PF_SEC_W]  == t[IDX_W-1 -: PF_SEC_W]);
         OP_PAGE: in_scope = (ix[IDX_W-1 -: PF_PGID_W] == t[IDX_W-1 -: PF_PGID_W]);
         default: in_scope = 1'b0;
      endcase
   endfunction

   assign rd_byte = mem[rd_idx];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
      end else if (done) begin
         if (kind == OP_PROG) begin
            mem[tgt] <= mem[tgt] & data;
         end else begin
            for (int i = 0; i < DEPTH; i++)
               if (in_scope(kind, tgt, IDX_W'(i))) mem[i] <= '1;
         end
      end
   end

endmodule

// File: rtl/pflash_cmd_ctrl.sv
module pflash_cmd_ctrl
   import pflash_pkg::*;
#(
   parameter int OFFS_BITS   = 2,
   parameter int PROG_CYCLES = 8,
   parameter int PAGE_CYCLES = 24,
   parameter int SECT_CYCLES = 24,
   parameter int CHIP_CYCLES = 48,
   parameter bit READ_REG    = 1'b1,
   localparam int IDX_W = PF_PGID_W + OFFS_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic              bus_re,
   input  logic [PF_AW-1:0]  bus_addr,
   input  logic [PF_DW-1:0]  bus_wdata,
   output logic [PF_DW-1:0]  bus_rdata,
   output logic              busy
);

   initial begin
      assert (OFFS_BITS >= 1 && OFFS_BITS <= PF_PGID_LSB)
         else $error("OFFS_BITS out of range");
      assert (PROG_CYCLES >= 1 && PAGE_CYCLES >= 1 && SECT_CYCLES >= 1 && CHIP_CYCLES >= 1)
         else $error("operation lengths must be at least one cycle");
   end

   logic             wr_ok, op_start, id_enter, id_exit, op_done;
   op_kind_e         new_kind, cur_kind;
   logic [IDX_W-1:0] new_idx, cur_idx, rd_idx;
   logic [PF_DW-1:0] new_data, cur_data, arr_byte, rd_val;
   logic             cur_d7;
   dec_state_e       dec_state;
   logic             id_q, tog_q;

   assign wr_ok  = bus_we && !busy;
   assign rd_idx = {bus_addr[PF_AW-1 -: PF_PGID_W], bus_addr[OFFS_BITS-1:0]};
   assign cur_d7 = cur_data[PF_DW-1];

   pflash_seq_decoder #(.OFFS_BITS(OFFS_BITS)) dec_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_ok), .addr(bus_addr), .data(bus_wdata),
      .start(op_start), .kind(new_kind), .idx(new_idx), .wdata(new_data),
      .id_enter(id_enter), .id_exit(id_exit), .state_o(dec_state)
   );

   pflash_op_timer #(
      .IDX_W(IDX_W), .PROG_CYCLES(PROG_CYCLES), .PAGE_CYCLES(PAGE_CYCLES),
      .SECT_CYCLES(SECT_CYCLES), .CHIP_CYCLES(CHIP_CYCLES)
   ) tmr_i (
      .clk(clk), .rst_n(rst_n), .start(op_start), .kind_in(new_kind),
      .idx_in(new_idx), .data_in(new_data), .busy(busy), .done(op_done),
      .kind_q(cur_kind), .idx_q(cur_idx), .data_q(cur_data)
   );

   pflash_store #(.OFFS_BITS(OFFS_BITS)) st_i (
      .clk(clk), .rst_n(rst_n), .done(op_done), .kind(cur_kind), .tgt(cur_idx),
      .data(cur_data), .rd_idx(rd_idx), .rd_byte(arr_byte)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         id_q  <= 1'b0;
         tog_q <= 1'b0;
      end else begin
         if (id_enter) id_q <= 1'b1;
         if (id_exit)  id_q <= 1'b0;
         if (op_start)              tog_q <= 1'b0;
         else if (bus_re && busy)   tog_q <= ~tog_q;
      end
   end

   always_comb begin
      if (busy) begin
         rd_val = {(cur_kind == OP_PROG) ? ~cur_d7 : 1'b0, tog_q, 6'b0};
      end else if (id_q) begin
         unique case (bus_addr[7:0])
            8'h00:   rd_val = ID_MAKER;
            8'h01:   rd_val = ID_PART;
            default: rd_val = '0;
         endcase
      end else begin
         rd_val = arr_byte;
      end
   end

   generate
      if (READ_REG) begin : g_rd_reg
         logic [PF_DW-1:0] rdata_q;
         always_ff @(posedge clk) begin
            if (!rst_n)      rdata_q <= '0;
            else if (bus_re) rdata_q <= rd_val;
         end
         assign bus_rdata = rdata_q;
      end else begin : g_rd_comb
         assign bus_rdata = rd_val;
      end
   endgenerate

endmodule

// File: rtl/pflash_cmd_chk.sv
module pflash_cmd_chk
   import pflash_pkg::*;
#(
   parameter bit READ_REG = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_we,
   input logic             bus_re,
   input logic [PF_AW-1:0] bus_addr,
   input logic [PF_DW-1:0] bus_wdata,
   input logic [PF_DW-1:0] bus_rdata,
   input logic             busy,
   input logic             id_q,
   input logic             tog_q,
   input logic             op_start,
   input op_kind_e         cur_kind,
   input logic             cur_d7,
   input dec_state_e       dec_state
);

   // R12
   reset_state_chk: assert property (@(posedge clk)
      $rose(rst_n) |-> (!busy && bus_rdata == 8'h00 && !id_q));

   // R9
   busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(bus_we));

   // R11
   no_start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !op_start);

   // R10
   abort_unl1_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_state == DS_UNL1 && bus_we && !busy &&
       !(bus_addr == PF_UNLOCK_B && bus_wdata == KEY_B)) |=> dec_state == DS_IDLE);

   // R8
   tog_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_re && busy) |=> tog_q != $past(tog_q));

   // R8
   tog_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!(bus_re && busy) && !op_start) |=> $stable(tog_q));

   generate
      if (READ_REG) begin : g_rd
         // R7
         prog_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (busy && bus_re && cur_kind == OP_PROG) |=> bus_rdata[7] == !$past(cur_d7));
         // R7
         erase_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (busy && bus_re && cur_kind != OP_PROG) |=> bus_rdata[7] == 1'b0);
         // R5
         id_maker_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (id_q && !busy && bus_re && bus_addr[7:0] == 8'h00) |=> bus_rdata == ID_MAKER);
         // R13
         rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !bus_re |=> $stable(bus_rdata));
      end
   endgenerate

endmodule

bind pflash_cmd_ctrl pflash_cmd_chk #(.READ_REG(READ_REG)) chk_i (
   .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
   .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy), .id_q(id_q),
   .tog_q(tog_q), .op_start(op_start), .cur_kind(cur_kind), .cur_d7(cur_d7),
   .dec_state(dec_state)
);

// File: tb/pflash_cmd_ctrl_tb_top.sv
module pflash_cmd_ctrl_tb_top;

   localparam int PROG_N = 8;
   localparam int CHIP_N = 48;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic        bus_re = 1'b0;
   logic [17:0] bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic        busy;

   int n_chk = 0;
   int n_fail = 0;
   bit ended = 1'b0;

   typedef struct {
      logic [7:0] exp;
      logic [7:0] mask;
      string      tag;
   } exp_t;
   exp_t sb_q[$];
   logic rd_seen = 1'b0;

   always #5 clk = ~clk;

   pflash_cmd_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   // monitor: pops one expected item per read strobe seen at the previous edge
   always @(posedge clk) rd_seen <= bus_re;
   always @(negedge clk) begin
      if (rd_seen) begin
         if (sb_q.size() == 0) begin
            check(1'b0, "scoreboard underflow", 0, 0);
         end else begin
            exp_t e;
            e = sb_q.pop_front();
            check((bus_rdata & e.mask) == (e.exp & e.mask), e.tag,
                  int'(bus_rdata & e.mask), int'(e.exp & e.mask));
         end
      end
   end

   task automatic wr(input logic [17:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [17:0] a, input logic [7:0] exp,
                     input logic [7:0] mask, input string tag);
      exp_t e;
      @(negedge clk);
      e.exp = exp; e.mask = mask; e.tag = tag;
      sb_q.push_back(e);
      bus_re = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_re = 1'b0;
   endtask

   task automatic unlock3(input logic [7:0] cmd);
      wr(18'h05555, 8'hAA); wr(18'h02AAA, 8'h55); wr(18'h05555, cmd);
   endtask

   task automatic program_byte(input logic [17:0] a, input logic [7:0] d);
      unlock3(8'hA0); wr(a, d);
   endtask

   task automatic erase(input logic [17:0] a, input logic [7:0] sel);
      unlock3(8'h80); wr(18'h05555, 8'hAA); wr(18'h02AAA, 8'h55); wr(a, sel);
   endtask

   task automatic wait_idle();
      while (busy) @(negedge clk);
   endtask

   task automatic count_busy(output int n);
      n = 0;
      while (busy) begin
         n++;
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      check(1'b0, "watchdog expired", 0, 0);
      finish_run();
   end

   initial begin
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R12
      check(busy == 1'b0, "R12 busy after reset", int'(busy), 0);
      check(bus_rdata == 8'h00, "R12 rdata after reset", int'(bus_rdata), 0);
      rd(18'h00000, 8'hFF, 8'hFF, "R12 array erased after reset");
      rd(18'h3F003, 8'hFF, 8'hFF, "R12 last byte erased after reset");

      // R1 / R7 / R8 program with status reads
      program_byte(18'h12001, 8'h5A);
      rd(18'h00000, 8'h80, 8'hFF, "R7 program poll bit7, R8 first toggle 0");
      rd(18'h3FFFF, 8'hC0, 8'hFF, "R8 toggle inverts on next read");
      wait_idle();
      rd(18'h12001, 8'h5A, 8'hFF, "R1 programmed byte, R7 data after done");
      program_byte(18'h12001, 8'h0F);
      count_busy(n);
      // R9
      check(n == PROG_N, "R9 program busy length", n, PROG_N);
      rd(18'h12001, 8'h0A, 8'hFF, "R1 program clears bits only");
      rd(18'h12FF1, 8'h0A, 8'hFF, "R1 alias address same byte");
      // R13
      @(negedge clk);
      check(bus_rdata == 8'h0A, "R13 rdata holds without read", int'(bus_rdata), 8'h0A);

      program_byte(18'h13002, 8'h33); wait_idle();
      program_byte(18'h20000, 8'h44); wait_idle();
      program_byte(18'h10000, 8'h11); wait_idle();

      // R4 page erase of page 0x12
      erase(18'h12ABC, 8'h50);
      rd(18'h00000, 8'h00, 8'hFF, "R7 erase poll bit7 0, R8 toggle 0");
      rd(18'h00000, 8'h40, 8'hFF, "R8 erase toggle 1");
      wait_idle();
      rd(18'h12001, 8'hFF, 8'hFF, "R4 page target erased");
      rd(18'h13002, 8'h33, 8'hFF, "R4 sibling page kept");
      rd(18'h10000, 8'h11, 8'hFF, "R4 other page kept");

      // R3 sector erase of sector 1
      erase(18'h1F000, 8'h30); wait_idle();
      rd(18'h13002, 8'hFF, 8'hFF, "R3 sector byte erased");
      rd(18'h10000, 8'hFF, 8'hFF, "R3 sector byte erased 2");
      rd(18'h20000, 8'h44, 8'hFF, "R3 other sector kept");

      // R2 chip erase with length check
      erase(18'h05555, 8'h10);
      count_busy(n);
      check(n == CHIP_N, "R9 chip busy length", n, CHIP_N);
      rd(18'h20000, 8'hFF, 8'hFF, "R2 chip erase clears all");

      // R10 broken sequences
      program_byte(18'h30000, 8'h00); wait_idle();
      wr(18'h05555, 8'hAA); wr(18'h02AAA, 8'h55); wr(18'h05555, 8'h77);
      wr(18'h30001, 8'h00);
      wr(18'h05555, 8'hAA); wr(18'h02AAA, 8'h54); wr(18'h05555, 8'hA0);
      wr(18'h30002, 8'h00);
      @(negedge clk);
      check(busy == 1'b0, "R10 no operation started", int'(busy), 0);
      rd(18'h30001, 8'hFF, 8'hFF, "R10 bad command no effect");
      rd(18'h30002, 8'hFF, 8'hFF, "R10 bad unlock no effect");
      rd(18'h30000, 8'h00, 8'hFF, "R10 prior data intact");

      // R11 commands during busy
      erase(18'h05555, 8'h10);
      program_byte(18'h30003, 8'h00);
      wait_idle();
      wr(18'h30003, 8'h00);
      @(negedge clk);
      check(busy == 1'b0, "R11 decoder not left pending", int'(busy), 0);
      rd(18'h30003, 8'hFF, 8'hFF, "R11 write during busy ignored");
      rd(18'h30000, 8'hFF, 8'hFF, "R11 erase completed normally");

      // R5 / R6 identification mode
      program_byte(18'h00002, 8'h21); wait_idle();
      unlock3(8'h90);
      rd(18'h00000, 8'hDA, 8'hFF, "R5 maker code");
      rd(18'h00001, 8'hB5, 8'hFF, "R5 part code");
      rd(18'h00002, 8'h00, 8'hFF, "R5 other offset zero");
      unlock3(8'hF0);
      rd(18'h00002, 8'h21, 8'hFF, "R6 normal read after exit");
      rd(18'h00000, 8'hFF, 8'hFF, "R6 offset 0 normal");

      repeat (3) @(negedge clk);
      check(sb_q.size() == 0, "scoreboard drained", sb_q.size(), 0);
      finish_run();
   end

endmodule